// File: doc/BRIEF.md
# Dual-Accumulator Fractional Multiply-Accumulate Unit

This block multiplies two 16-bit signed operands and folds the product into one of two 40-bit accumulators in a single clock. Each operand is sign-extended to 17 bits before the multiply. The product is used either as a plain integer or, in fractional (Q15) mode, doubled by a one-bit left shift. The 40-bit accumulators hold a 32-bit value under 8 guard bits. The largest fractional product, minus one times minus one, therefore lands in the guard bits and does not wrap.

A caller issues one command per cycle on a valid-qualified port. The command carries an operation code, an accumulator index, the fractional/integer choice and a saturation enable, together with the two operands. The updated accumulator value and its overflow flags appear on the readback ports one clock after the command is accepted. With saturation enabled, a result outside the signed 32-bit range is clamped. Each accumulator keeps two sticky overflow flags, and only a clear command resets them.

Top module: `mac_dual_acc`

## Requirements
- R1: While reset is asserted, and on the first cycles after its release, both accumulators read zero and all four overflow flags read zero.
- R2: In integer mode (`cmd_frac`=0) the product equals the signed 16x16 product of the operands, sign-extended to 40 bits; 0x8000 x 0x8000 gives 0x0040000000.
- R3: In fractional mode (`cmd_frac`=1) the product is the signed product shifted left by one; 0x8000 x 0x8000 gives 0x0080000000 with saturation off.
- R4: `cmd_op` encodes 0 = clear, 1 = load product, 2 = add product (MAC), 3 = subtract product (MSC). The result shows on the selected accumulator output one clock after the command is accepted.
- R5: Only the accumulator addressed by `cmd_sel` (0 selects acc0, 1 selects acc1) changes. When `cmd_valid` is low, no accumulator or flag changes.
- R6: With `cmd_sat`=1, a result above 0x007FFFFFFF is stored as 0x007FFFFFFF, and a result below 0xFF80000000 is stored as 0xFF80000000.
- R7: With `cmd_sat`=0, the result wraps modulo 2^40 (for example 0x7F80000000 + 0x0080000000 gives 0x8000000000).
- R8: `ovf32_o[i]` is set when an unsaturated result of accumulator i lies outside the signed 32-bit range. Once set, it stays set until that accumulator is cleared.
- R9: `ovf40_o[i]` is set when the exact result of accumulator i lies outside the signed 40-bit range. Once set, it stays set until that accumulator is cleared.
- R10: A clear command sets the selected accumulator to zero and resets both of its overflow flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command accepted on this clock edge |
| cmd_op | input | 2 | Operation: 0 clear, 1 load, 2 MAC, 3 MSC |
| cmd_sel | input | 1 | Accumulator index |
| cmd_frac | input | 1 | 1 = fractional (product doubled), 0 = integer |
| cmd_sat | input | 1 | 1 = clamp to signed 32-bit range |
| opnd_a | input | 16 | First signed operand |
| opnd_b | input | 16 | Second signed operand |
| acc0_o | output | 40 | Accumulator 0 |
| acc1_o | output | 40 | Accumulator 1 |
| ovf32_o | output | 2 | Sticky 32-bit overflow flag per accumulator |
| ovf40_o | output | 2 | Sticky 40-bit overflow flag per accumulator |

## Verification
On a single update, the saturation clamp and the capture of the sticky 32-bit overflow flag fire in the same cycle, and they must agree. The fractional minus-one-squared load with saturation on, and a second negative MAC that crosses the lower bound, both force the two to coincide. Each is judged by reading the clamped value and the newly set flag together on the cycle after the command. The 40-bit wrap is provoked by 256 maximal fractional MACs. This case pairs with the setting of the 40-bit flag in the same way.

// File: rtl/mac_pkg.sv
package mac_pkg;

  localparam int NUM_ACC = 2;

  typedef enum logic [1:0] {
    OP_CLR  = 2'd0,
    OP_LOAD = 2'd1,
    OP_MAC  = 2'd2,
    OP_MSC  = 2'd3
  } mac_op_e;

endpackage

// File: rtl/mac_rst_sync.sv
module mac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  input  logic             frac_i,
  output logic [ACC_W-1:0] prod_o
);

  // operands sign-extended past the 17-bit multiplier width
  localparam int PROD_W = 2 * (OP_W + 1);

  logic signed [PROD_W-1:0] a_wide;
  logic signed [PROD_W-1:0] b_wide;
  logic signed [PROD_W-1:0] raw;
  logic signed [ACC_W-1:0]  ext;

  always_comb begin
    a_wide = {{(PROD_W-OP_W){a_i[OP_W-1]}}, a_i};
    b_wide = {{(PROD_W-OP_W){b_i[OP_W-1]}}, b_i};
    raw    = a_wide * b_wide;
    ext    = {{(ACC_W-PROD_W){raw[PROD_W-1]}}, raw};
    prod_o = frac_i ? (ext <<< 1) : ext;
  end

  localparam logic [OP_W-1:0]  OP_MIN   = {1'b1, {(OP_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] FRAC_TOP = {{(ACC_W-2*OP_W){1'b0}}, 1'b1, {(2*OP_W-1){1'b0}}};

  AST_INT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (!frac_i && a_i != '0 && b_i != '0) |-> (prod_o[ACC_W-1] == (a_i[OP_W-1] ^ b_i[OP_W-1]))); // R2

  AST_FRAC_MINUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_i && a_i == OP_MIN && b_i == OP_MIN) |-> (prod_o == FRAC_TOP)); // R3

endmodule

// File: rtl/mac_acc_update.sv
module mac_acc_update
  import mac_pkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int GUARD_W = 8
) (
  input  mac_op_e          op_i,
  input  logic             sat_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] prod_i,
  output logic [ACC_W-1:0] acc_nxt_o,
  output logic             hit32_o,
  output logic             hit40_o
);

  localparam int SUM_W = ACC_W + 1;
  localparam int VAL_W = ACC_W - GUARD_W;
  localparam int TOP_W = SUM_W - VAL_W + 1;
  localparam logic [ACC_W-1:0] POS_MAX = {{(GUARD_W+1){1'b0}}, {(VAL_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_MIN = {{(GUARD_W+1){1'b1}}, {(VAL_W-1){1'b0}}};

  logic [SUM_W-1:0] acc_x;
  logic [SUM_W-1:0] prod_x;
  logic [SUM_W-1:0] sum;
  logic [TOP_W-1:0] top_bits;

  always_comb begin
    acc_x  = {acc_i[ACC_W-1], acc_i};
    prod_x = {prod_i[ACC_W-1], prod_i};
    unique case (op_i)
      OP_CLR:  sum = '0;
      OP_LOAD: sum = prod_x;
      OP_MAC:  sum = acc_x + prod_x;
      OP_MSC:  sum = acc_x - prod_x;
      default: sum = '0;
    endcase
    top_bits = sum[SUM_W-1:VAL_W-1];
    hit40_o  = sum[SUM_W-1] ^ sum[SUM_W-2];
    hit32_o  = (top_bits != {TOP_W{1'b0}}) && (top_bits != {TOP_W{1'b1}});
    if (sat_i && hit32_o) acc_nxt_o = sum[SUM_W-1] ? NEG_MIN : POS_MAX;
    else                  acc_nxt_o = sum[ACC_W-1:0];
  end

endmodule

// File: rtl/mac_acc_bank.sv
module mac_acc_bank
  import mac_pkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int GUARD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  mac_op_e          op_i,
  input  logic             sat_i,
  input  logic [ACC_W-1:0] acc_nxt_i,
  input  logic             hit32_i,
  input  logic             hit40_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             ovf32_o,
  output logic             ovf40_o
);

  localparam int VAL_W = ACC_W - GUARD_W;
  localparam int TOP_W = GUARD_W + 1;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic             ovf32_q, ovf32_d;
  logic             ovf40_q, ovf40_d;
  logic             clr_cmd;

  always_comb begin
    clr_cmd = hit_i && (op_i == OP_CLR);
    acc_d   = acc_nxt_i;
    ovf32_d = clr_cmd ? 1'b0 : (ovf32_q | hit32_i);
    ovf40_d = clr_cmd ? 1'b0 : (ovf40_q | hit40_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      ovf32_q <= 1'b0;
      ovf40_q <= 1'b0;
    end else if (hit_i) begin
      acc_q   <= acc_d;
      ovf32_q <= ovf32_d;
      ovf40_q <= ovf40_d;
    end
  end

  assign acc_o   = acc_q;
  assign ovf32_o = ovf32_q;
  assign ovf40_o = ovf40_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && op_i == OP_CLR) |=> (acc_q == '0 && !ovf32_q && !ovf40_q)); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_i) |=> ($stable(acc_q) && $stable(ovf32_q) && $stable(ovf40_q))); // R5

  AST_STICKY32: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf32_q && !(hit_i && op_i == OP_CLR)) |=> ovf32_q); // R8

  AST_STICKY40: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf40_q && !(hit_i && op_i == OP_CLR)) |=> ovf40_q); // R9

  AST_SAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && sat_i) |=> ((acc_q[ACC_W-1:VAL_W-1] == {TOP_W{1'b0}}) ||
                          (acc_q[ACC_W-1:VAL_W-1] == {TOP_W{1'b1}}))); // R6

endmodule

// File: rtl/mac_dual_acc.sv
module mac_dual_acc
  import mac_pkg::*;
#(
  parameter int OP_W    = 16,
  parameter int ACC_W   = 40,
  parameter int GUARD_W = 8,
  parameter int SEL_W   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [SEL_W-1:0]   cmd_sel,
  input  logic               cmd_frac,
  input  logic               cmd_sat,
  input  logic [OP_W-1:0]    opnd_a,
  input  logic [OP_W-1:0]    opnd_b,
  output logic [ACC_W-1:0]   acc0_o,
  output logic [ACC_W-1:0]   acc1_o,
  output logic [NUM_ACC-1:0] ovf32_o,
  output logic [NUM_ACC-1:0] ovf40_o
);

  logic             rst_sync_n;
  logic [ACC_W-1:0] prod;
  mac_op_e          op;
  logic [ACC_W-1:0] acc_q   [NUM_ACC];
  logic [ACC_W-1:0] acc_nxt [NUM_ACC];
  logic [NUM_ACC-1:0] hit, hit32, hit40;

  assign op = mac_op_e'(cmd_op);

  mac_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .a_i    (opnd_a),
    .b_i    (opnd_b),
    .frac_i (cmd_frac),
    .prod_o (prod)
  );

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    assign hit[g] = cmd_valid && (cmd_sel == SEL_W'(g));

    mac_acc_update #(.ACC_W(ACC_W), .GUARD_W(GUARD_W)) u_update (
      .op_i      (op),
      .sat_i     (cmd_sat),
      .acc_i     (acc_q[g]),
      .prod_i    (prod),
      .acc_nxt_o (acc_nxt[g]),
      .hit32_o   (hit32[g]),
      .hit40_o   (hit40[g])
    );

    mac_acc_bank #(.ACC_W(ACC_W), .GUARD_W(GUARD_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .hit_i     (hit[g]),
      .op_i      (op),
      .sat_i     (cmd_sat),
      .acc_nxt_i (acc_nxt[g]),
      .hit32_i   (hit32[g]),
      .hit40_i   (hit40[g]),
      .acc_o     (acc_q[g]),
      .ovf32_o   (ovf32_o[g]),
      .ovf40_o   (ovf40_o[g])
    );
  end

  assign acc0_o = acc_q[0];
  assign acc1_o = acc_q[1];

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(hit)); // R5

endmodule

// File: tb/test_mac_dual_acc.sv
`timescale 1ns/1ps
module test_mac_dual_acc;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [0:0]  cmd_sel;
  logic        cmd_frac, cmd_sat;
  logic [15:0] opnd_a, opnd_b;
  logic [39:0] acc0_o, acc1_o;
  logic [1:0]  ovf32_o, ovf40_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  mac_dual_acc i_mac_dual_acc (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .cmd_frac(cmd_frac), .cmd_sat(cmd_sat),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .acc0_o(acc0_o), .acc1_o(acc1_o),
    .ovf32_o(ovf32_o), .ovf40_o(ovf40_o)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic        sel;
    logic        frac;
    logic        sat;
    logic [15:0] a;
    logic [15:0] b;
    logic [39:0] e0;
    logic [39:0] e1;
    logic [1:0]  e32;
  } vec_t;

  // op/sel/frac/sat/a/b -> expected acc0, acc1, ovf32 (R2 R3 R4 R5 R8)
  localparam vec_t VECS [8] = '{
    '{2'd1, 1'b0, 1'b0, 1'b0, 16'h0003, 16'h0005, 40'h000000000F, 40'h0000000000, 2'b00},
    '{2'd2, 1'b0, 1'b0, 1'b0, 16'hFFFE, 16'h0007, 40'h0000000001, 40'h0000000000, 2'b00},
    '{2'd3, 1'b0, 1'b0, 1'b0, 16'h0004, 16'h0004, 40'hFFFFFFFFF1, 40'h0000000000, 2'b00},
    '{2'd1, 1'b1, 1'b1, 1'b0, 16'h4000, 16'h4000, 40'hFFFFFFFFF1, 40'h0020000000, 2'b00},
    '{2'd2, 1'b1, 1'b1, 1'b0, 16'h8000, 16'h4000, 40'hFFFFFFFFF1, 40'hFFE0000000, 2'b00},
    '{2'd0, 1'b1, 1'b0, 1'b0, 16'h1234, 16'h5678, 40'hFFFFFFFFF1, 40'h0000000000, 2'b00},
    '{2'd1, 1'b1, 1'b1, 1'b0, 16'h8000, 16'h8000, 40'hFFFFFFFFF1, 40'h0080000000, 2'b10},
    '{2'd0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 40'h0000000000, 40'h0080000000, 2'b10}
  };

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic sel, input logic frac,
                       input logic sat, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    cmd_op = op; cmd_sel = sel; cmd_frac = frac; cmd_sat = sat;
    opnd_a = a; opnd_b = b; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_sel = 1'b0;
    cmd_frac = 1'b0; cmd_sat = 1'b0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    chk("R1 acc0 in reset", acc0_o, 40'h0);
    chk("R1 acc1 in reset", acc1_o, 40'h0);
    chk("R1 flags in reset", {36'h0, ovf32_o, ovf40_o}, 40'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 acc0 after release", acc0_o, 40'h0);

    for (int i = 0; i < 8; i++) begin
      issue(VECS[i].op, VECS[i].sel, VECS[i].frac, VECS[i].sat, VECS[i].a, VECS[i].b);
      chk($sformatf("R4 vec%0d acc0", i), acc0_o, VECS[i].e0);
      chk($sformatf("R5 vec%0d acc1", i), acc1_o, VECS[i].e1);
      chk($sformatf("R8 vec%0d ovf32", i), {38'h0, ovf32_o}, {38'h0, VECS[i].e32});
    end

    // R5: command without valid is ignored
    @(negedge clk);
    cmd_op = 2'd2; cmd_sel = 1'b1; cmd_frac = 1'b1; opnd_a = 16'h4000; opnd_b = 16'h4000;
    @(negedge clk);
    @(negedge clk);
    chk("R5 idle acc1", acc1_o, 40'h0080000000);
    chk("R5 idle acc0", acc0_o, 40'h0);

    // R6 positive clamp with flag in same cycle
    issue(2'd1, 1'b0, 1'b1, 1'b1, 16'h8000, 16'h8000);
    chk("R6 pos clamp", acc0_o, 40'h007FFFFFFF);
    chk("R8 flag with clamp", {39'h0, ovf32_o[0]}, 40'h1);
    issue(2'd3, 1'b0, 1'b1, 1'b1, 16'h4000, 16'h4000);
    chk("R6 back in range", acc0_o, 40'h005FFFFFFF);
    chk("R8 ovf32 sticky", {39'h0, ovf32_o[0]}, 40'h1);
    issue(2'd0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0);
    chk("R10 clear acc0", acc0_o, 40'h0);
    chk("R10 clear ovf32", {39'h0, ovf32_o[0]}, 40'h0);

    // R6 negative clamp
    issue(2'd1, 1'b0, 1'b1, 1'b1, 16'h8000, 16'h7FFF);
    chk("R3 frac neg load", acc0_o, 40'hFF80010000);
    chk("R8 no flag in range", {39'h0, ovf32_o[0]}, 40'h0);
    issue(2'd2, 1'b0, 1'b1, 1'b1, 16'h8000, 16'h7FFF);
    chk("R6 neg clamp", acc0_o, 40'hFF80000000);
    chk("R8 flag neg clamp", {39'h0, ovf32_o[0]}, 40'h1);

    // R7/R9: wrap at 40 bits
    issue(2'd0, 1'b1, 1'b0, 1'b0, 16'h0, 16'h0);
    for (int k = 0; k < 255; k++) issue(2'd2, 1'b1, 1'b1, 1'b0, 16'h8000, 16'h8000);
    chk("R7 before wrap", acc1_o, 40'h7F80000000);
    chk("R9 no ovf40 yet", {39'h0, ovf40_o[1]}, 40'h0);
    chk("R8 ovf32 acc1", {39'h0, ovf32_o[1]}, 40'h1);
    issue(2'd2, 1'b1, 1'b1, 1'b0, 16'h8000, 16'h8000);
    chk("R7 wrap", acc1_o, 40'h8000000000);
    chk("R9 ovf40 set", {39'h0, ovf40_o[1]}, 40'h1);
    issue(2'd2, 1'b1, 1'b1, 1'b0, 16'h8000, 16'h8000);
    chk("R7 after wrap", acc1_o, 40'h8080000000);
    chk("R9 ovf40 sticky", {39'h0, ovf40_o[1]}, 40'h1);
    chk("R5 acc0 untouched", acc0_o, 40'hFF80000000);
    chk("R9 acc0 ovf40 clear", {39'h0, ovf40_o[0]}, 40'h0);
    issue(2'd0, 1'b1, 1'b0, 1'b0, 16'h0, 16'h0);
    chk("R10 clear acc1", acc1_o, 40'h0);
    chk("R10 clear flags acc1", {38'h0, ovf32_o[1], ovf40_o[1]}, 40'h0);

    // R2 integer minus-one case
    issue(2'd1, 1'b1, 1'b0, 1'b0, 16'h8000, 16'h8000);
    chk("R2 int min*min", acc1_o, 40'h0040000000);
    issue(2'd1, 1'b1, 1'b0, 1'b0, 16'h7FFF, 16'hFFFF);
    chk("R2 int neg", acc1_o, 40'hFFFFFF8001);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 acc0 re-reset", acc0_o, 40'h0);
    chk("R1 acc1 re-reset", acc1_o, 40'h0);
    chk("R1 flags re-reset", {36'h0, ovf32_o, ovf40_o}, 40'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule